// File: doc/BRIEF.md
# Address Translation Buffer with Hardware Refill and Access Rights

This block sits between a processor's load/store path and memory. Each access presents a virtual address, a read/write flag, a privilege flag and the current process identifier. A small fully associative array of cached page table entries is searched by virtual page number and process tag. On a hit, the block returns the physical address (cached frame number joined to the untouched page offset) in the same cycle, or flags a protection fault when the access rights held in the entry forbid the access.

On a miss, a refill engine reads the entry from a single-level page table in memory. The table is indexed by the process tag and virtual page number together, so one table base covers every process. An entry whose present bit is clear yields a page fault and is not cached. A present entry is placed into the lowest free slot or, when every slot is occupied, into the slot named by a round-robin pointer. The old occupant's entry, carrying its updated usage and dirty bits, is written back to its own table location before the new one is installed. A flush input empties the array in one cycle.

The requester holds its request stable until it sees `resp_valid`. The memory side holds each read or write request until it is answered.

Top module: `xlat_tlb`

## Requirements
- R1: After reset no entry is valid, `resp_valid`, `mem_rd_req` and `mem_wr_req` are low, and the first access to any page causes a table read.
- R2: In the idle state, a request whose page number and process tag match a valid entry raises `resp_valid` in the same cycle with `resp_paddr` = {cached frame number, request offset} and no fault, without any memory transaction.
- R3: On a miss the block raises `mem_rd_req` with `mem_rd_addr` = `table_base` + 4 × {`cur_pid`, page number}. It installs the returned entry and then answers the held request as a hit.
- R4: A table entry is laid out as bit 0 present, bits 2:1 kernel rights, bits 4:3 user rights, bit 5 referenced, bit 6 dirty, bit 7 cacheable, upper bits frame number. A fetched entry with bit 0 clear produces one response with `page_fault` high and is not installed, so a repeat of the same access reads the table again.
- R5: Rights are encoded as 00 no access, 01 read only, 10 or 11 read/write. Kernel requests use the kernel field and user requests use the user field. A forbidden access produces a response with `prot_fault` high. Every faulting response drives `resp_paddr` to zero, and the two fault outputs are never high together.
- R6: A permitted hit sets the entry's referenced bit, and a permitted write hit also sets its dirty bit. A faulting access changes neither bit. The bits become visible in the written-back entry.
- R7: A present entry fetched on a miss goes to the lowest-numbered free slot. When all slots are valid it goes to the slot given by a round-robin pointer that starts at slot 0 and advances by one after each such eviction. Page faults do not advance the pointer.
- R8: Before replacing an occupied slot, the block raises `mem_wr_req` with the victim's address (computed from the victim's own process tag and page number) and its full entry with bit 0 set. It waits for `mem_wr_ack` before installing. No write-back happens when a free slot is used.
- R9: A flush invalidates every entry by the next cycle, so later accesses to previously cached pages miss.
- R10: An entry whose page number matches but whose process tag differs from `cur_pid` does not hit.
- R11: Memory read and write requests are never high together. A read request stays high with a stable address until `mem_rd_valid`, and each miss issues exactly one table read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all entries |
| table_base | input | PA_W | Physical byte address of the page table |
| req_valid | input | 1 | Translation request, held until `resp_valid` |
| req_vaddr | input | VPN_W+OFF_W | Virtual address: page number above offset |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_kernel | input | 1 | 1 = kernel privilege, 0 = user |
| cur_pid | input | PID_W | Current process tag |
| resp_valid | output | 1 | Response for the held request |
| resp_paddr | output | PA_W | Physical address, zero on a fault |
| page_fault | output | 1 | Table entry not present |
| prot_fault | output | 1 | Access rights forbid the access |
| mem_rd_req | output | 1 | Table read request |
| mem_rd_addr | output | PA_W | Table read byte address |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | PPN_W+8 | Fetched table entry |
| mem_wr_req | output | 1 | Victim write-back request |
| mem_wr_addr | output | PA_W | Write-back byte address |
| mem_wr_data | output | PPN_W+8 | Victim entry with current flags |
| mem_wr_ack | input | 1 | Write-back accepted |

## Verification
The bench builds the block with two entries, an 8-bit page number, a 4-bit process tag, a 12-bit frame number and a 12-bit offset. With only two slots, the third distinct page already forces evictions. A short sequence therefore walks the round-robin pointer through several wraps, produces write-backs that expose the referenced and dirty bits set by earlier hits, and shows that faulting fetches neither evict nor advance the pointer. The narrow page number lets the bench pick pages whose low bits select each user-rights code and whose high nibble marks an entry as not present. The bench computes its own model table from these rules.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;

  // Table entry flag layout; the refill path and the write-back path agree on it.
  localparam int FLAG_W  = 8;
  localparam int FL_PRES = 0;
  localparam int FL_KRW  = 1;
  localparam int FL_URW  = 3;
  localparam int FL_REF  = 5;
  localparam int FL_DIRT = 6;
  localparam int FL_CACH = 7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WBACK,
    ST_FAULT
  } refill_st_e;

  // 00 none, 01 read only, 1x read/write
  function automatic logic rights_ok(input logic [1:0] rw, input logic is_write);
    if (rw == 2'b00) return 1'b0;
    if (is_write) return rw[1];
    return 1'b1;
  endfunction

endpackage

// File: rtl/xlat_tlb_entries.sv
module xlat_tlb_entries
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 4,
  parameter int PPN_W   = 20,
  localparam int IX_W   = $clog2(ENTRIES),
  localparam int PTE_W  = PPN_W + FLAG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [PID_W-1:0]   lk_pid,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [IX_W-1:0]    hit_idx,
  output logic [PPN_W-1:0]   hit_ppn,
  output logic [1:0]         hit_krw,
  output logic [1:0]         hit_urw,
  input  logic               ins_en,
  input  logic [IX_W-1:0]    ins_idx,
  input  logic [PTE_W-1:0]   ins_pte,
  input  logic               touch_en,
  input  logic [IX_W-1:0]    touch_idx,
  input  logic               touch_dirty,
  input  logic [IX_W-1:0]    rd_idx,
  output logic [VPN_W-1:0]   rd_vpn,
  output logic [PID_W-1:0]   rd_pid,
  output logic [PTE_W-1:0]   rd_pte,
  output logic [ENTRIES-1:0] valid_vec
);

  logic [VPN_W-1:0]    e_vpn [ENTRIES];
  logic [PID_W-1:0]    e_pid [ENTRIES];
  logic [PPN_W-1:0]    e_ppn [ENTRIES];
  logic [FLAG_W-1:1]   e_fl  [ENTRIES];

  // Valid bits: flush wins over a same-cycle install.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_vec <= '0;
    end else if (flush) begin
      valid_vec <= '0;
    end else if (ins_en) begin
      valid_vec[ins_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (ins_en && ins_idx == IX_W'(i)) begin
        e_vpn[i] <= lk_vpn;
        e_pid[i] <= lk_pid;
        e_ppn[i] <= ins_pte[PTE_W-1:FLAG_W];
        e_fl[i]  <= ins_pte[FLAG_W-1:1];
      end else if (touch_en && touch_idx == IX_W'(i)) begin
        e_fl[i][FL_REF] <= 1'b1;
        if (touch_dirty) e_fl[i][FL_DIRT] <= 1'b1;
      end
    end
  end

  always_comb begin
    hit_idx = '0;
    hit_ppn = '0;
    hit_krw = '0;
    hit_urw = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_vec[i] = valid_vec[i] && (e_vpn[i] == lk_vpn) && (e_pid[i] == lk_pid);
      if (hit_vec[i]) begin
        hit_idx = IX_W'(i);
        hit_ppn = hit_ppn | e_ppn[i];
        hit_krw = hit_krw | e_fl[i][FL_KRW+1:FL_KRW];
        hit_urw = hit_urw | e_fl[i][FL_URW+1:FL_URW];
      end
    end
  end

  assign rd_vpn = e_vpn[rd_idx];
  assign rd_pid = e_pid[rd_idx];
  assign rd_pte = {e_ppn[rd_idx], e_fl[rd_idx], 1'b1};

endmodule

// File: rtl/xlat_tlb_victim.sv
module xlat_tlb_victim #(
  parameter int ENTRIES = 4,
  localparam int IX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               advance,
  output logic [IX_W-1:0]    victim_idx,
  output logic               full
);

  logic [IX_W-1:0] rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else if (advance) rr_q <= (rr_q == IX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  // Lowest free slot first; the pointer only matters when none is free.
  always_comb begin
    full       = &valid_vec;
    victim_idx = rr_q;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) victim_idx = IX_W'(i);
    end
  end

endmodule

// File: rtl/xlat_tlb_refill.sv
module xlat_tlb_refill
  import xlat_tlb_pkg::*;
#(
  parameter int PTE_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss,
  input  logic             full,
  input  logic             rd_valid,
  input  logic [PTE_W-1:0] rd_data,
  input  logic             wr_ack,
  output logic             idle,
  output logic             rd_req,
  output logic             wr_req,
  output logic             fault_resp,
  output logic             install,
  output logic [PTE_W-1:0] ins_pte
);

  refill_st_e      st_q, st_d;
  logic [PTE_W-1:0] pte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      pte_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_FETCH && rd_valid) pte_q <= rd_data;
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (miss) st_d = ST_FETCH;
      ST_FETCH: if (rd_valid) begin
        if (!rd_data[FL_PRES]) st_d = ST_FAULT;
        else if (full)         st_d = ST_WBACK;
        else                   st_d = ST_IDLE;
      end
      ST_WBACK: if (wr_ack) st_d = ST_IDLE;
      ST_FAULT: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign idle       = (st_q == ST_IDLE);
  assign rd_req     = (st_q == ST_FETCH);
  assign wr_req     = (st_q == ST_WBACK);
  assign fault_resp = (st_q == ST_FAULT);
  assign install    = (rd_req && rd_valid && rd_data[FL_PRES] && !full) || (wr_req && wr_ack);
  assign ins_pte    = wr_req ? pte_q : rd_data;

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int PID_W   = 4,
  parameter int PPN_W   = 20,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PTE_W  = PPN_W + FLAG_W,
  localparam int IX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [PA_W-1:0]  table_base,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_kernel,
  input  logic [PID_W-1:0] cur_pid,
  output logic             resp_valid,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             page_fault,
  output logic             prot_fault,
  output logic             mem_rd_req,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [PTE_W-1:0] mem_rd_data,
  output logic             mem_wr_req,
  output logic [PA_W-1:0]  mem_wr_addr,
  output logic [PTE_W-1:0] mem_wr_data,
  input  logic             mem_wr_ack
);

  // Table location of an entry: one word per {process, page} pair.
  function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] base,
                                                 input logic [PID_W-1:0] pid,
                                                 input logic [VPN_W-1:0] vpn);
    return base + (PA_W'({pid, vpn}) << 2);
  endfunction

  logic [VPN_W-1:0]   req_vpn;
  logic [OFF_W-1:0]   req_off;
  logic [ENTRIES-1:0] hit_vec, valid_vec;
  logic [IX_W-1:0]    hit_idx, victim_idx;
  logic [PPN_W-1:0]   hit_ppn;
  logic [1:0]         hit_krw, hit_urw, use_rw;
  logic [VPN_W-1:0]   vic_vpn;
  logic [PID_W-1:0]   vic_pid;
  logic [PTE_W-1:0]   ins_pte;
  logic               idle, full, install, fault_resp;
  logic               lookup_hit, lookup_miss, access_ok, touch_en;

  assign req_vpn = req_vaddr[VA_W-1:OFF_W];
  assign req_off = req_vaddr[OFF_W-1:0];

  xlat_tlb_entries #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W), .PPN_W(PPN_W)
  ) u_entries (
    .clk, .rst_n, .flush,
    .lk_vpn(req_vpn), .lk_pid(cur_pid),
    .hit_vec, .hit_idx, .hit_ppn, .hit_krw, .hit_urw,
    .ins_en(install), .ins_idx(victim_idx), .ins_pte,
    .touch_en, .touch_idx(hit_idx), .touch_dirty(req_write),
    .rd_idx(victim_idx), .rd_vpn(vic_vpn), .rd_pid(vic_pid), .rd_pte(mem_wr_data),
    .valid_vec
  );

  xlat_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk, .rst_n, .valid_vec,
    .advance(install && full),
    .victim_idx, .full
  );

  xlat_tlb_refill #(.PTE_W(PTE_W)) u_refill (
    .clk, .rst_n,
    .miss(lookup_miss), .full,
    .rd_valid(mem_rd_valid), .rd_data(mem_rd_data), .wr_ack(mem_wr_ack),
    .idle, .rd_req(mem_rd_req), .wr_req(mem_wr_req),
    .fault_resp, .install, .ins_pte
  );

  assign lookup_hit  = idle && req_valid && (|hit_vec);
  assign lookup_miss = idle && req_valid && !(|hit_vec) && !flush;
  assign use_rw      = req_kernel ? hit_krw : hit_urw;
  assign access_ok   = rights_ok(use_rw, req_write);
  assign touch_en    = lookup_hit && access_ok;

  assign resp_valid  = lookup_hit || fault_resp;
  assign page_fault  = fault_resp;
  assign prot_fault  = lookup_hit && !access_ok;
  assign resp_paddr  = touch_en ? {hit_ppn, req_off} : '0;

  assign mem_rd_addr = entry_addr(table_base, cur_pid, req_vpn);
  assign mem_wr_addr = entry_addr(table_base, vic_pid, vic_vpn);

endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int ENTRIES = 4,
  parameter int PA_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] valid_vec,
  input logic               resp_valid,
  input logic [PA_W-1:0]    resp_paddr,
  input logic               page_fault,
  input logic               prot_fault,
  input logic               mem_rd_req,
  input logic               mem_rd_valid,
  input logic [PA_W-1:0]    mem_rd_addr,
  input logic               mem_wr_req,
  input logic               wb_present
);

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2

  AST_FAULT_KINDS: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !(page_fault && prot_fault)); // R5

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && (page_fault || prot_fault)) |-> (resp_paddr == '0)); // R5

  AST_PF_IS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    page_fault |-> resp_valid); // R4

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req)); // R11

  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr))); // R11

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0)); // R9

  AST_WB_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> wb_present); // R8

endmodule

bind xlat_tlb xlat_tlb_chk #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .hit_vec(hit_vec), .valid_vec(valid_vec),
  .resp_valid(resp_valid), .resp_paddr(resp_paddr),
  .page_fault(page_fault), .prot_fault(prot_fault),
  .mem_rd_req(mem_rd_req), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
  .mem_wr_req(mem_wr_req), .wb_present(mem_wr_data[0])
);

// File: tb/xlat_tlb_test.sv
`timescale 1ns/1ps
module xlat_tlb_test;

  localparam int ENT = 2, VW = 8, OW = 12, PW = 4, FW = 12;
  localparam int AW = FW + OW, EW = FW + 8;
  localparam logic [AW-1:0] BASE = 24'h100000;

  logic clk = 0, rst_n = 0, flush = 0;
  logic req_valid = 0, req_write = 0, req_kernel = 0;
  logic [VW+OW-1:0] req_vaddr = '0;
  logic [PW-1:0] cur_pid = '0;
  logic resp_valid, page_fault, prot_fault, mem_rd_req, mem_wr_req;
  logic [AW-1:0] resp_paddr, mem_rd_addr, mem_wr_addr;
  logic [EW-1:0] mem_wr_data, mem_rd_data = '0;
  logic mem_rd_valid = 0, mem_wr_ack = 0;

  always #4 clk = ~clk;

  xlat_tlb #(.ENTRIES(ENT), .VPN_W(VW), .OFF_W(OW), .PID_W(PW), .PPN_W(FW)) uut (
    .clk, .rst_n, .flush, .table_base(BASE), .req_valid, .req_vaddr, .req_write,
    .req_kernel, .cur_pid, .resp_valid, .resp_paddr, .page_fault, .prot_fault,
    .mem_rd_req, .mem_rd_addr, .mem_rd_valid, .mem_rd_data,
    .mem_wr_req, .mem_wr_addr, .mem_wr_data, .mem_wr_ack
  );

  int checks = 0, fails = 0, cyc = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [AW-1:0] last_rd_addr = '0, last_wr_addr = '0;
  logic [EW-1:0] last_wr_data = '0;

  // Model table: present unless the page's high nibble is F; kernel rights
  // read/write; user rights from page bits 1:0; frame = {page, process}.
  function automatic logic [EW-1:0] model_entry(input logic [PW-1:0] p, input logic [VW-1:0] v);
    return {v, p, v[0], 1'b0, 1'b0, v[1:0], 2'b11, (v[7:4] != 4'hF)};
  endfunction

  function automatic logic [AW-1:0] model_addr(input logic [PW-1:0] p, input logic [VW-1:0] v);
    return BASE + {10'd0, p, v, 2'b00};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model, acting on falling edges.
  initial forever begin
    @(negedge clk);
    mem_rd_valid = 0;
    mem_wr_ack = 0;
    if (mem_wr_req) begin
      wr_cnt++;
      last_wr_addr = mem_wr_addr;
      last_wr_data = mem_wr_data;
      mem_wr_ack = 1;
    end else if (mem_rd_req) begin
      logic [AW-1:0] ix;
      rd_cnt++;
      last_rd_addr = mem_rd_addr;
      ix = (mem_rd_addr - BASE) >> 2;
      mem_rd_data = model_entry(ix[11:8], ix[7:0]);
      mem_rd_valid = 1;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  // Vector: pid, vpn, off, write, kernel, exp pf, exp prot, exp read, exp wb,
  // wb pid, wb vpn, wb ref, wb dirty, pad.
  localparam logic [49:0] VEC [14] = '{
    {4'd1, 8'h11, 12'h123, 1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b0, 4'd0, 8'h00, 1'b0,1'b0, 6'd0}, // miss R3
    {4'd1, 8'h11, 12'h456, 1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b0, 4'd0, 8'h00, 1'b0,1'b0, 6'd0}, // hit R2
    {4'd1, 8'h11, 12'h001, 1'b1,1'b0, 1'b0,1'b1, 1'b0,1'b0, 4'd0, 8'h00, 1'b0,1'b0, 6'd0}, // user write read-only R5
    {4'd1, 8'h11, 12'h002, 1'b1,1'b1, 1'b0,1'b0, 1'b0,1'b0, 4'd0, 8'h00, 1'b0,1'b0, 6'd0}, // kernel write sets dirty
    {4'd2, 8'h11, 12'hABC, 1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b0, 4'd0, 8'h00, 1'b0,1'b0, 6'd0}, // other pid misses R10
    {4'd1, 8'hF3, 12'h010, 1'b0,1'b1, 1'b1,1'b0, 1'b1,1'b0, 4'd0, 8'h00, 1'b0,1'b0, 6'd0}, // not present R4
    {4'd1, 8'hF3, 12'h010, 1'b0,1'b1, 1'b1,1'b0, 1'b1,1'b0, 4'd0, 8'h00, 1'b0,1'b0, 6'd0}, // still not cached R4
    {4'd1, 8'h12, 12'h777, 1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b1, 4'd1, 8'h11, 1'b1,1'b1, 6'd0}, // evict slot0 R7 R8
    {4'd1, 8'h12, 12'h778, 1'b1,1'b0, 1'b0,1'b0, 1'b0,1'b0, 4'd0, 8'h00, 1'b0,1'b0, 6'd0}, // user write rw hit
    {4'd1, 8'h11, 12'hFFF, 1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b1, 4'd2, 8'h11, 1'b1,1'b0, 6'd0}, // evict slot1 R6
    {4'd2, 8'h10, 12'h000, 1'b0,1'b0, 1'b0,1'b1, 1'b1,1'b1, 4'd1, 8'h12, 1'b1,1'b1, 6'd0}, // install then no-access
    {4'd3, 8'h13, 12'h321, 1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b1, 4'd1, 8'h11, 1'b1,1'b0, 6'd0}, // evict slot1
    {4'd1, 8'h23, 12'h654, 1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b1, 4'd2, 8'h10, 1'b0,1'b0, 6'd0}, // faulted entry clean R6
    {4'd3, 8'h13, 12'h0F0, 1'b1,1'b0, 1'b0,1'b0, 1'b0,1'b0, 4'd0, 8'h00, 1'b0,1'b0, 6'd0}  // hit survives
  };

  task automatic run(input logic [49:0] v);
    logic [PW-1:0] p; logic [VW-1:0] pg; logic [OW-1:0] off;
    logic e_pf, e_pr, e_rd, e_wb;
    int rd0, wr0;
    bit got;
    logic r_pf, r_pr; logic [AW-1:0] r_pa, e_pa;
    string tag;
    logic [EW-1:0] e_wd;
    p = v[49:46]; pg = v[45:38]; off = v[37:26];
    e_pf = v[23]; e_pr = v[22]; e_rd = v[21]; e_wb = v[20];
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    cur_pid = p; req_vaddr = {pg, off}; req_write = v[25]; req_kernel = v[24]; req_valid = 1;
    #1;
    got = 0;
    for (int k = 0; k < 50 && !got; k++) begin
      if (resp_valid) begin
        got = 1; r_pf = page_fault; r_pr = prot_fault; r_pa = resp_paddr;
      end else begin
        @(negedge clk); #1;
      end
    end
    @(posedge clk); #1;
    req_valid = 0;
    tag = e_pf ? "R4" : e_pr ? "R5" : e_rd ? "R3" : "R2";
    check(got, {tag, " response"}, 32'(got), 32'd1);
    if (!got) return;
    e_pa = (e_pf || e_pr) ? '0 : {pg, p, off};
    check(r_pf == e_pf, {tag, " page_fault"}, 32'(r_pf), 32'(e_pf));
    check(r_pr == e_pr, {tag, " prot_fault"}, 32'(r_pr), 32'(e_pr));
    check(r_pa == e_pa, {tag, " paddr"}, 32'(r_pa), 32'(e_pa));
    check(rd_cnt - rd0 == int'(e_rd), "R11 table reads", 32'(rd_cnt - rd0), 32'(e_rd));
    if (e_rd) check(last_rd_addr == model_addr(p, pg), "R3 read addr", 32'(last_rd_addr), 32'(model_addr(p, pg)));
    check(wr_cnt - wr0 == int'(e_wb), "R7 write-backs", 32'(wr_cnt - wr0), 32'(e_wb));
    if (e_wb) begin
      e_wd = model_entry(v[19:16], v[15:8]);
      e_wd[5] = v[7]; e_wd[6] = v[6];
      check(last_wr_addr == model_addr(v[19:16], v[15:8]), "R8 wb addr", 32'(last_wr_addr), 32'(model_addr(v[19:16], v[15:8])));
      check(last_wr_data == e_wd, "R6 wb data", 32'(last_wr_data), 32'(e_wd));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    check(!resp_valid, "R1 resp_valid", 32'(resp_valid), 0);
    check(!mem_rd_req, "R1 mem_rd_req", 32'(mem_rd_req), 0);
    check(!mem_wr_req, "R1 mem_wr_req", 32'(mem_wr_req), 0);
    foreach (VEC[i]) run(VEC[i]);
    // R9: flush, then cached page misses and refills into free slots, no write-back
    @(negedge clk) flush = 1;
    @(negedge clk) flush = 0;
    run({4'd3, 8'h13, 12'h0F1, 1'b0,1'b0, 1'b0,1'b0, 1'b1,1'b0, 4'd0, 8'h00, 1'b0,1'b0, 6'd0}); // R9
    run({4'd1, 8'h30, 12'h0F2, 1'b0,1'b1, 1'b0,1'b0, 1'b1,1'b0, 4'd0, 8'h00, 1'b0,1'b0, 6'd0}); // R7 free slot
    run({4'd3, 8'h13, 12'h0F3, 1'b0,1'b0, 1'b0,1'b0, 1'b0,1'b0, 4'd0, 8'h00, 1'b0,1'b0, 6'd0}); // R2 kept
    run({4'd1, 8'h30, 12'h0F4, 1'b0,1'b0, 1'b0,1'b1, 1'b0,1'b0, 4'd0, 8'h00, 1'b0,1'b0, 6'd0}); // R5 user none
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule